// File: doc/BRIEF.md
# Hardwired Accumulator Processor Core

This block is a small processor with one 16-bit accumulator, a 12-bit program counter and a 12-bit address space of 16-bit words. Every instruction is built from a run of numbered steps. A step counter advances once per clock. Each register transfer is enabled by the decoded opcode together with the current step. Each instruction clears the counter on its last step, so the next fetch starts at step 0. The instruction word has three fields. Bit 15 is the indirect flag. Bits 14..12 are the opcode. Bits 11..0 are the address, or a one-hot operation field when the opcode is 7.

The core drives a synchronous single-port memory. The memory registers the address on a clock edge and returns that word on `mem_rdata` during the following cycle. To meet this, the core puts out the address of a read one cycle before the step that consumes the data. A write presents its address, data and `mem_we` in the same cycle. The core also has a character input and a character output, each with a ready flag. When interrupts are enabled and either flag is set, a separate request block arms a hardware interrupt cycle. That cycle saves the return address in word 0 and continues at word 1.

Top module: `accu_core`

## Requirements
- R1: After reset the program counter is 0, the core is stopped (`running`=0), interrupts are disabled with no request pending, `in_ready`=0, `out_ready`=1, and no memory write occurs while `start` stays low.
- R2: A `start` pulse sets the run flag. While the flag is clear, the step counter and all registers hold and no write is issued. HLT (0x7001) clears the flag at the end of its last step. A later `start` resumes at the word after the HLT.
- R3: Fetch takes 3 cycles and step 3 always follows it. Register and I/O instructions take 4 cycles in total. STA and BUN take 5. AND, ADD, LDA and BSA take 6. ISZ takes 7. The interrupt cycle takes 3.
- R4: With bit 15 set, a memory-reference instruction (opcode 0..6) replaces its address with bits 11..0 of the addressed word at step 3.
- R5: AND (opcode 0) ANDs the operand into the accumulator. ADD (1) adds the operand and puts the carry-out in E. LDA (2) loads the operand. STA (3) stores the accumulator.
- R6: BUN (4) jumps to the effective address. BSA (5) writes the return address into the effective address and continues at effective address + 1.
- R7: ISZ (6) writes back the operand + 1 and skips the next word when the result is 0.
- R8: With opcode 7 and bit 15 = 0, these bits select the register operations: bit 11 clears AC, bit 10 clears E, bit 9 inverts AC, bit 8 inverts E, bit 7 rotates {AC,E} right through E, bit 6 rotates it left through E, bit 5 increments AC, bit 0 halts.
- R9: The skip bits are bit 4 (AC[15]=0), bit 3 (AC[15]=1), bit 2 (AC=0) and bit 1 (E=0). An I/O skip uses bit 9 (input ready) or bit 8 (output ready). A skip whose condition holds advances the program counter by exactly one more.
- R10: With opcode 7 and bit 15 = 1, the I/O operations are selected by these bits. Bit 11 copies the input character into AC[7:0] and clears `in_ready`. Bit 10 copies AC[7:0] to `out_char` and clears `out_ready`. Bit 7 enables interrupts and bit 6 disables them. `in_strobe` captures `in_char` and sets `in_ready`. `out_ack` sets `out_ready`.
- R11: A request is armed in any step from 3 on when interrupts are enabled and a ready flag is set. The next instruction is then replaced by a cycle that writes the program counter to word 0, sets the program counter to 1 and disables interrupts.
- R12: Each read address appears on `mem_addr` one cycle before the step that uses `mem_rdata`. A write drives `mem_addr`, `mem_wdata` and `mem_we` in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sets the run flag |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| in_char | input | 8 | Character from the input device |
| in_strobe | input | 1 | Device has a new character; captures it |
| in_ready | output | 1 | Input character waiting |
| out_char | output | 8 | Character for the output device |
| out_ack | input | 1 | Device has taken the output character |
| out_ready | output | 1 | Output register free |
| running | output | 1 | Run flag |

## Verification
A wrong register value shows at the memory port as a wrong address or wrong data on the next write that depends on it. It can also show as a jump to an unexpected word, which changes every later write. A wrong step count or a missed end of instruction moves each following write by whole cycles, and the total number of running cycles no longer matches. The bench runs an instruction-level model next to the core. It checks every write on the clock where it happens, so the first bad transfer is reported within one instruction.

// File: rtl/accu_core.sv
module accu_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic enable,
  input  logic in_ready,
  input  logic out_ready,
  input  logic clear,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else if (clear) pending <= 1'b0;
    else if (arm && enable && (in_ready || out_ready)) pending <= 1'b1;
  end

  a_r11_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(enable));
endmodule

module accu_core #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  input  logic [CW-1:0] in_char,
  input  logic          in_strobe,
  output logic          in_ready,
  output logic [CW-1:0] out_char,
  input  logic          out_ack,
  output logic          out_ready,
  output logic          running
);
  localparam int LAST = 6;
  localparam int PADW = DW - AW;

  logic [AW-1:0] ar_q, ar_n, pc_q;
  logic [DW-1:0] dr_q, ac_q, ir_q, tr_q;
  logic          e_q, run_q, ind_q, ien_q, inf_q, outf_q, irq;
  logic [SW-1:0] step_q;
  logic [CW-1:0] inbuf_q, outc_q;
  logic [7:0]    d;
  logic [LAST:0] t;

  assign d = 8'b1 << ir_q[DW-2:DW-4];

  for (genvar k = 0; k <= LAST; k++) begin : g_step
    assign t[k] = run_q && (step_q == SW'(k));
  end

  wire [AW-1:0] b    = ir_q[AW-1:0];
  wire          rr   = t[3] && d[7] && !ind_q;
  wire          io   = t[3] && d[7] && ind_q;
  wire          acz  = (ac_q == '0);
  wire          skip = (rr && ((b[4] && !ac_q[DW-1]) || (b[3] && ac_q[DW-1]) ||
                               (b[2] && acz) || (b[1] && !e_q))) ||
                       (io && ((b[9] && inf_q) || (b[8] && outf_q)));
  wire          done = (t[2] && irq) || (t[3] && d[7]) || (t[4] && (d[3] || d[4])) ||
                       (t[5] && (d[0] || d[1] || d[2] || d[5])) || (t[6] && d[6]);
  wire [DW:0]   sum  = {1'b0, ac_q} + {1'b0, dr_q};

  always_comb begin
    ar_n = ar_q;
    if (t[0]) ar_n = irq ? '0 : pc_q;
    if (t[2] && !irq) ar_n = ir_q[AW-1:0];
    if (t[3] && !d[7] && ind_q) ar_n = mem_rdata[AW-1:0];
    if (t[4] && d[5]) ar_n = ar_q + 1'b1;
  end

  assign mem_we = (t[1] && irq) || (t[4] && (d[3] || d[5])) || (t[6] && d[6]);
  assign mem_addr = mem_we ? ar_q : ar_n;
  assign mem_wdata = (t[1] && irq)   ? tr_q :
                     (t[4] && d[3])  ? ac_q :
                     (t[4] && d[5])  ? {{PADW{1'b0}}, pc_q} : dr_q;

  accu_irq i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (run_q && step_q >= SW'(3)),
    .enable   (ien_q),
    .in_ready (inf_q),
    .out_ready(outf_q),
    .clear    (t[2] && irq),
    .pending  (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ar_q <= '0; pc_q <= '0; dr_q <= '0; ac_q <= '0; ir_q <= '0; tr_q <= '0;
      e_q <= 1'b0; run_q <= 1'b0; ind_q <= 1'b0; ien_q <= 1'b0;
      inf_q <= 1'b0; outf_q <= 1'b1; step_q <= '0; inbuf_q <= '0; outc_q <= '0;
    end else begin
      if (start) run_q <= 1'b1;
      if (in_strobe) begin inbuf_q <= in_char; inf_q <= 1'b1; end
      if (out_ack) outf_q <= 1'b1;
      if (run_q) step_q <= done ? '0 : step_q + 1'b1;
      ar_q <= ar_n;

      if (t[0] && irq) tr_q <= {{PADW{1'b0}}, pc_q};
      if (t[1]) begin
        if (irq) pc_q <= '0;
        else begin ir_q <= mem_rdata; pc_q <= pc_q + 1'b1; end
      end
      if (t[2]) begin
        if (irq) begin pc_q <= pc_q + 1'b1; ien_q <= 1'b0; end
        else ind_q <= ir_q[DW-1];
      end

      if (rr) begin
        if (b[11]) ac_q <= '0;
        if (b[10]) e_q <= 1'b0;
        if (b[9])  ac_q <= ~ac_q;
        if (b[8])  e_q <= ~e_q;
        if (b[7])  begin ac_q <= {e_q, ac_q[DW-1:1]}; e_q <= ac_q[0]; end
        if (b[6])  begin ac_q <= {ac_q[DW-2:0], e_q}; e_q <= ac_q[DW-1]; end
        if (b[5])  ac_q <= ac_q + 1'b1;
        if (b[0])  run_q <= 1'b0;
      end
      if (io) begin
        if (b[11]) begin ac_q[CW-1:0] <= inbuf_q; inf_q <= 1'b0; end
        if (b[10]) begin outc_q <= ac_q[CW-1:0]; outf_q <= 1'b0; end
        if (b[7])  ien_q <= 1'b1;
        if (b[6])  ien_q <= 1'b0;
      end
      if (skip) pc_q <= pc_q + 1'b1;

      if (t[4]) begin
        if (d[0] || d[1] || d[2] || d[6]) dr_q <= mem_rdata;
        if (d[4]) pc_q <= ar_q;
      end
      if (t[5]) begin
        if (d[0]) ac_q <= ac_q & dr_q;
        if (d[1]) begin ac_q <= sum[DW-1:0]; e_q <= sum[DW]; end
        if (d[2]) ac_q <= dr_q;
        if (d[5]) pc_q <= ar_q;
        if (d[6]) dr_q <= dr_q + 1'b1;
      end
      if (t[6] && d[6] && dr_q == '0) pc_q <= pc_q + 1'b1;
    end
  end

  assign in_ready  = inf_q;
  assign out_ready = outf_q;
  assign out_char  = outc_q;
  assign running   = run_q;

  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> ($stable(pc_q) && $stable(ac_q) && $stable(step_q)));
  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= SW'(LAST));
  a_r9_skip_one: assert property (@(posedge clk) disable iff (!rst_n)
    (t[3] && skip) |=> (pc_q == $past(pc_q) + 1'b1));
  a_r11_vector_write: assert property (@(posedge clk) disable iff (!rst_n)
    (t[1] && irq) |-> (mem_we && mem_addr == '0));
  a_r6_link_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (t[5] && d[5]) |=> (pc_q == $past(ar_q)));
endmodule

// File: tb/test_accu_core.sv
`timescale 1ns/1ps
module test_accu_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic mem_we;
  logic [7:0] in_char = 8'h00;
  logic in_strobe = 1'b0;
  logic in_ready;
  logic [7:0] out_char;
  logic out_ack = 1'b0;
  logic out_ready;
  logic running;

  always #2.5 clk = ~clk;

  accu_core i_accu_core (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .in_char(in_char), .in_strobe(in_strobe), .in_ready(in_ready),
    .out_char(out_char), .out_ack(out_ack), .out_ready(out_ready), .running(running)
  );

  logic [15:0] mem [4096];
  logic [15:0] rm [4096];
  logic [15:0] rd_q = 16'h0;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    rd_q <= mem[mem_addr];
  end

  int checks = 0, errors = 0, cyc = 0, exp_cycles = 0;
  logic [27:0] wq [$];

  logic [11:0] m_pc;
  logic [15:0] m_ac;
  logic m_e, m_ien, m_irq, m_fgi, m_fgo;
  logic [7:0] m_inbuf, m_outc;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (running) cyc++;
      if (mem_we) begin
        if (wq.size() == 0) chk("R12 unexpected write", {4'h0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
        else begin
          logic [27:0] w;
          w = wq.pop_front();
          chk("R12 write addr/data", {4'h0, mem_addr, mem_wdata}, {4'h0, w});
        end
      end
    end
  end

  task automatic model_reset();
    m_pc = 0; m_ac = 0; m_e = 0; m_ien = 0; m_irq = 0;
    m_fgi = 0; m_fgo = 1; m_inbuf = 0; m_outc = 0;
  endtask

  task automatic mwrite(logic [11:0] a, logic [15:0] v);
    rm[a] = v;
    wq.push_back({a, v});
  endtask

  task automatic model_run();
    bit halted = 0;
    exp_cycles = 0;
    while (!halted) begin
      logic [15:0] inst, opnd;
      logic [11:0] a;
      logic [2:0] op;
      logic pre, sk;
      if (m_irq) begin
        mwrite(12'h000, {4'h0, m_pc});
        m_pc = 12'h001; m_ien = 0; m_irq = 0;
        exp_cycles += 3;
        continue;
      end
      inst = rm[m_pc];
      m_pc = m_pc + 1;
      op = inst[14:12];
      a = inst[11:0];
      pre = m_ien && (m_fgi || m_fgo);
      exp_cycles += 4;
      if (op == 3'd7 && !inst[15]) begin
        sk = (inst[4] && !m_ac[15]) || (inst[3] && m_ac[15]) ||
             (inst[2] && m_ac == 0) || (inst[1] && !m_e);
        case (1'b1)
          inst[11]: m_ac = 0;
          inst[10]: m_e = 0;
          inst[9]:  m_ac = ~m_ac;
          inst[8]:  m_e = ~m_e;
          inst[7]:  {m_ac, m_e} = {m_e, m_ac};
          inst[6]:  {m_e, m_ac} = {m_ac, m_e};
          inst[5]:  m_ac = m_ac + 1;
          inst[0]:  halted = 1;
          default: ;
        endcase
        if (sk) m_pc = m_pc + 1;
      end else if (op == 3'd7) begin
        sk = (inst[9] && m_fgi) || (inst[8] && m_fgo);
        if (inst[11]) begin m_ac[7:0] = m_inbuf; m_fgi = 0; end
        if (inst[10]) begin m_outc = m_ac[7:0]; m_fgo = 0; end
        if (inst[7]) m_ien = 1;
        if (inst[6]) m_ien = 0;
        if (sk) m_pc = m_pc + 1;
      end else begin
        if (inst[15]) a = rm[a][11:0];
        opnd = rm[a];
        case (op)
          3'd0: begin m_ac = m_ac & opnd; exp_cycles += 2; end
          3'd1: begin {m_e, m_ac} = {1'b0, m_ac} + {1'b0, opnd}; exp_cycles += 2; end
          3'd2: begin m_ac = opnd; exp_cycles += 2; end
          3'd3: begin mwrite(a, m_ac); exp_cycles += 1; end
          3'd4: begin m_pc = a; exp_cycles += 1; end
          3'd5: begin mwrite(a, {4'h0, m_pc}); m_pc = a + 1; exp_cycles += 2; end
          default: begin
            opnd = opnd + 1;
            mwrite(a, opnd);
            if (opnd == 0) m_pc = m_pc + 1;
            exp_cycles += 3;
          end
        endcase
      end
      m_irq = pre;
    end
  endtask

  task automatic put(logic [11:0] a, logic [15:0] v);
    mem[a] = v; rm[a] = v;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic run_seg(string tag);
    int guard = 0;
    model_run();
    cyc = 0;
    start = 1; @(negedge clk); start = 0;
    @(negedge clk);
    while (running && guard < 5000) begin @(negedge clk); guard++; end
    chk({"R3 cycles ", tag}, cyc, exp_cycles);
    chk({"R2 halted ", tag}, {31'd0, running}, 32'd0);
    chk({"R12 writes done ", tag}, wq.size(), 0);
    chk({"R10 out_char ", tag}, {24'd0, out_char}, {24'd0, m_outc});
    chk({"R10 out_ready ", tag}, {31'd0, out_ready}, {31'd0, m_fgo});
    chk({"R10 in_ready ", tag}, {31'd0, in_ready}, {31'd0, m_fgi});
  endtask

  task automatic cmp_mem(string tag);
    for (int a = 0; a < 'h300; a++) chk({"R5 mem ", tag}, {16'd0, mem[a]}, {16'd0, rm[a]});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 4096; a++) begin mem[a] = 16'h0; rm[a] = 16'h0; end
    do_reset();
    repeat (4) @(negedge clk);
    chk("R1 running", {31'd0, running}, 0);
    chk("R1 in_ready", {31'd0, in_ready}, 0);
    chk("R1 out_ready", {31'd0, out_ready}, 1);
    chk("R1 no write", {31'd0, mem_we}, 0);

    put(12'h000, 16'h2050); put(12'h001, 16'h1051); put(12'h002, 16'h3060);
    put(12'h003, 16'h7040); put(12'h004, 16'h3061); put(12'h005, 16'h7200);
    put(12'h006, 16'h7020); put(12'h007, 16'h0052); put(12'h008, 16'h3062);
    put(12'h009, 16'h7400); put(12'h00A, 16'h7100); put(12'h00B, 16'h7080);
    put(12'h00C, 16'h3063); put(12'h00D, 16'hA053); put(12'h00E, 16'h3064);
    put(12'h00F, 16'h7004); put(12'h010, 16'h3065); put(12'h011, 16'h7800);
    put(12'h012, 16'h7004); put(12'h013, 16'h3066); put(12'h014, 16'h7010);
    put(12'h015, 16'h3067); put(12'h016, 16'h7008); put(12'h017, 16'h6054);
    put(12'h018, 16'h3068); put(12'h019, 16'h5070); put(12'h01A, 16'h7002);
    put(12'h01B, 16'h3069); put(12'h01C, 16'h7001); put(12'h01D, 16'h7020);
    put(12'h01E, 16'hB055); put(12'h01F, 16'h7001);
    put(12'h050, 16'hC3A5); put(12'h051, 16'h8F0F); put(12'h052, 16'h0FF0);
    put(12'h053, 16'h0051); put(12'h054, 16'hFFFF); put(12'h055, 16'h007E);
    put(12'h071, 16'h7020); put(12'h072, 16'h306A); put(12'h073, 16'hC070);
    run_seg("prog1");
    chk("R4 indirect load", {16'd0, mem[12'h064]}, 32'h8F0F);
    chk("R7 isz wrap", {16'd0, mem[12'h054]}, 0);
    chk("R9 skipped store", {16'd0, mem[12'h066]}, 0);
    chk("R6 link word", {16'd0, mem[12'h070]}, 32'h001A);
    chk("R8 rotate left", {16'd0, mem[12'h061]}, {16'd0, rm[12'h061]});
    repeat (20) @(negedge clk);
    chk("R2 stays halted", {31'd0, running}, 0);
    run_seg("resume");
    cmp_mem("prog1");

    do_reset();
    @(negedge clk); in_char = 8'h5A; in_strobe = 1; @(negedge clk); in_strobe = 0;
    m_inbuf = 8'h5A; m_fgi = 1;
    chk("R10 strobe sets ready", {31'd0, in_ready}, 1);
    put(12'h000, 16'hF200); put(12'h001, 16'h7001); put(12'h002, 16'hF800);
    put(12'h003, 16'hF100); put(12'h004, 16'h7001); put(12'h005, 16'hF400);
    put(12'h006, 16'hF100); put(12'h007, 16'h4009); put(12'h008, 16'h7001);
    put(12'h009, 16'hF200); put(12'h00A, 16'h3040); put(12'h00B, 16'h7001);
    run_seg("io");
    chk("R10 char out", {24'd0, out_char}, 32'h5A);
    @(negedge clk); out_ack = 1; @(negedge clk); out_ack = 0;
    chk("R10 ack sets ready", {31'd0, out_ready}, 1);
    cmp_mem("io");

    do_reset();
    put(12'h000, 16'h4100); put(12'h001, 16'h4200);
    put(12'h100, 16'hF080); put(12'h101, 16'h7800);
    put(12'h200, 16'hF040); put(12'h201, 16'h7001);
    run_seg("irq");
    chk("R11 saved return", {16'd0, mem[12'h000]}, 32'h0102);
    cmp_mem("irq");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule